// File: doc/BRIEF.md
# Shared-Operator Multiply-Add Engine

The engine evaluates z = a*b + c + d for a stream of operand sets while owning exactly one multiplier and one adder. The multiplier is a two-stage unit: it starts on one cycle and its product is written into the x register at the end of the following cycle. The adder takes one cycle. It is reached through a pair of operand selectors, one choice giving (c, d) and the other (x, y). Its output passes a two-way demultiplexer that writes either the partial sum y or the final result z. A small controller drives every register enable and every select.

A source offers an operand set with `in_valid`, and the set is taken on the clock edge that ends a cycle in which `in_ready` is also high. Each finished result is shown on `z_out` with a single-cycle `z_valid` pulse. The parameter `OVERLAP` chooses the controller's timetable. At 0 it runs a sequential timetable: three cycles per result, so n back-to-back sets finish in 3n cycles. At 1 it runs a pipelined timetable in which the final addition of one set shares a cycle with the multiply start of the next: two cycles per result, and n back-to-back sets finish in 2n+1 cycles.

Top module: `shared_muladd`

## Requirements
- R1: During and directly after synchronous active-high reset, `z_valid` is 0, the controller is idle and `in_ready` is 1.
- R2: An operand set is captured on the edge ending a cycle with `in_valid` and `in_ready` both high. `in_ready` is high only while idle or in the last step of the timetable.
- R3: Every reported `z_out` equals (a*b + c + d) mod 2^W for the operand set it belongs to, and results leave in acceptance order.
- R4: `z_valid` rises in the fourth cycle after the accepting cycle and stays high for exactly one cycle.
- R5: With OVERLAP=0, `in_ready` is low for the two cycles after an acceptance, and n back-to-back sets finish in 3n cycles counted from the first accepting edge.
- R6: With OVERLAP=1, `in_ready` is low for the one cycle after an acceptance, and n back-to-back sets finish in 2n+1 cycles counted the same way.
- R7: The single adder writes y only from (c, d) and z only from (x, y), and it never writes both in one cycle.
- R8: The x register is loaded exactly one cycle after each multiply start, so a product is ready two edges after its operands are applied.
- R9: Overflow wraps: all-ones operands give all-ones z, and all-zero operands give zero.
- R10: Operand values offered while `in_ready` is low are ignored and do not affect any result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source offers an operand set |
| in_ready | output | 1 | Engine can take an operand set this cycle |
| a_in | input | W | Multiplicand |
| b_in | input | W | Multiplier operand |
| c_in | input | W | First addend |
| d_in | input | W | Second addend |
| z_out | output | W | Result register |
| z_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
In the pipelined timetable, the final addition of one set and the multiply start of the next fall in the same cycle. Acceptance of a new set also falls on the cycle that computes the partial sum y of the set in flight. Both collisions are forced by holding `in_valid` high for long stretches, so that each mode runs strictly back-to-back. They are judged by a behavioural model that predicts, clock by clock, `in_ready`, the `z_valid` cycle and the wrapped value of every result, and that times the fourth result against 2n+1 and 3n. Random gaps in `in_valid`, with junk operands offered while not ready, then exercise the idle and drain paths.

// File: rtl/muladd_pkg.sv
package muladd_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SQ_MUL,
    S_SQ_XLD,
    S_SQ_SUM,
    S_PL_MUL,
    S_PL_MULZ,
    S_PL_XLD,
    S_PL_DRAIN
  } ctl_state_t;

  typedef struct packed {
    logic mul_go;
    logic ldx;
    logic sel_xy;
    logic dmx_z;
    logic ldy;
    logic ldz;
    logic rdy;
  } ctl_t;

endpackage

// File: rtl/muladd_ctrl.sv
module muladd_ctrl
  import muladd_pkg::*;
#(
  parameter bit OVERLAP = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output ctl_t ctl
);

  ctl_state_t state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  generate
    if (OVERLAP) begin : g_pipelined
      always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
          S_IDLE: begin
            ctl.rdy = 1'b1;
            if (in_valid) state_d = S_PL_MUL;
          end
          S_PL_MUL: begin
            ctl.mul_go = 1'b1;
            state_d    = S_PL_XLD;
          end
          S_PL_MULZ: begin
            ctl.mul_go = 1'b1;
            ctl.sel_xy = 1'b1;
            ctl.dmx_z  = 1'b1;
            ctl.ldz    = 1'b1;
            state_d    = S_PL_XLD;
          end
          S_PL_XLD: begin
            ctl.ldx = 1'b1;
            ctl.ldy = 1'b1;
            ctl.rdy = 1'b1;
            state_d = in_valid ? S_PL_MULZ : S_PL_DRAIN;
          end
          S_PL_DRAIN: begin
            ctl.sel_xy = 1'b1;
            ctl.dmx_z  = 1'b1;
            ctl.ldz    = 1'b1;
            ctl.rdy    = 1'b1;
            state_d    = in_valid ? S_PL_MUL : S_IDLE;
          end
          default: state_d = S_IDLE;
        endcase
      end
    end else begin : g_sequential
      always_comb begin
        ctl     = '0;
        state_d = state_q;
        case (state_q)
          S_IDLE: begin
            ctl.rdy = 1'b1;
            if (in_valid) state_d = S_SQ_MUL;
          end
          S_SQ_MUL: begin
            ctl.mul_go = 1'b1;
            ctl.ldy    = 1'b1;
            state_d    = S_SQ_XLD;
          end
          S_SQ_XLD: begin
            ctl.ldx = 1'b1;
            state_d = S_SQ_SUM;
          end
          S_SQ_SUM: begin
            ctl.sel_xy = 1'b1;
            ctl.dmx_z  = 1'b1;
            ctl.ldz    = 1'b1;
            ctl.rdy    = 1'b1;
            state_d    = in_valid ? S_SQ_MUL : S_IDLE;
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  endgenerate

  // R7: one adder result per cycle, demux steering matches the enable
  p_single_add_r7: assert property (@(posedge clk) disable iff (rst)
    !(ctl.ldy && ctl.ldz));
  p_demux_y_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.ldy |-> (!ctl.dmx_z && !ctl.sel_xy));
  p_demux_z_r7: assert property (@(posedge clk) disable iff (rst)
    ctl.ldz |-> (ctl.dmx_z && ctl.sel_xy));

endmodule

// File: rtl/muladd_dp.sv
module muladd_dp
  import muladd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] d_in,
  input  ctl_t         ctl,
  output logic [W-1:0] z_q
);

  function automatic logic [W-1:0] wrap_mul(input logic [W-1:0] p, input logic [W-1:0] q);
    return p * q;
  endfunction

  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] p, input logic [W-1:0] q);
    return p + q;
  endfunction

  logic [W-1:0] a_q, b_q, c_q, d_q;
  logic [W-1:0] m_q, x_q, y_q;
  logic [W-1:0] opnd_l, opnd_r, sum;
  logic [W-1:0] dmx_to_y, dmx_to_z;

  always_ff @(posedge clk) begin
    if (ld_in) begin
      a_q <= a_in;
      b_q <= b_in;
      c_q <= c_in;
      d_q <= d_in;
    end
  end

  // multiplier: stage register, then x register
  always_ff @(posedge clk) begin
    if (ctl.mul_go) m_q <= wrap_mul(a_q, b_q);
    if (ctl.ldx)    x_q <= m_q;
  end

  // operand selectors, shared adder, result demux
  assign opnd_l   = ctl.sel_xy ? x_q : c_q;
  assign opnd_r   = ctl.sel_xy ? y_q : d_q;
  assign sum      = wrap_add(opnd_l, opnd_r);
  assign dmx_to_y = ctl.dmx_z ? '0  : sum;
  assign dmx_to_z = ctl.dmx_z ? sum : '0;

  always_ff @(posedge clk) begin
    if (ctl.ldy) y_q <= dmx_to_y;
    if (ctl.ldz) z_q <= dmx_to_z;
  end

  // R8: x follows each multiply start by exactly one cycle
  p_mul_two_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.ldx |-> $past(ctl.mul_go));
  p_mul_lands_r8: assert property (@(posedge clk) disable iff (rst)
    ctl.mul_go |=> ctl.ldx);

endmodule

// File: rtl/shared_muladd.sv
module shared_muladd
  import muladd_pkg::*;
#(
  parameter int W       = 16,
  parameter bit OVERLAP = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] c_in,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] z_out,
  output logic         z_valid
);

  ctl_t ctl;
  logic accept;

  muladd_ctrl #(.OVERLAP(OVERLAP)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .ctl     (ctl)
  );

  assign in_ready = ctl.rdy;
  assign accept   = in_valid && in_ready;

  muladd_dp #(.W(W)) u_dp (
    .clk  (clk),
    .rst  (rst),
    .ld_in(accept),
    .a_in (a_in),
    .b_in (b_in),
    .c_in (c_in),
    .d_in (d_in),
    .ctl  (ctl),
    .z_q  (z_out)
  );

  always_ff @(posedge clk) begin
    if (rst) z_valid <= 1'b0;
    else     z_valid <= ctl.ldz;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!z_valid && in_ready));
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    z_valid |=> !z_valid);

  generate
    if (OVERLAP) begin : g_chk_pl
      p_ready_gap_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);
    end else begin : g_chk_sq
      p_ready_gap_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);
      p_ready_gap2_r5: assert property (@(posedge clk) disable iff (rst)
        $past(accept, 2) |-> !in_ready);
    end
  endgenerate

endmodule

// File: tb/shared_muladd_tb.sv
`timescale 1ns/1ps
module shared_muladd_tb;

  localparam int W = 16;
  localparam longint MASK = (64'd1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go  = 1'b0;

  always #4 clk = ~clk;

  for (genvar m = 0; m < 2; m++) begin : g_mode
    localparam bit OV  = (m == 1);
    localparam int GAP = OV ? 2 : 3;

    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] a = '0, b = '0, c = '0, d = '0;
    logic [W-1:0] z_out;
    logic         z_valid;

    int chk  = 0;
    int bad  = 0;
    bit done = 1'b0;

    shared_muladd #(.W(W), .OVERLAP(OV)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .a_in(a), .b_in(b), .c_in(c), .d_in(d),
      .z_out(z_out), .z_valid(z_valid)
    );

    int           t        = 0;
    int           last_acc = -1000;
    int           first_acc = -1;
    int           n_out    = 0;
    int           q_cyc[$];
    logic [W-1:0] q_val[$];
    bit           q_wrap[$];

    always @(negedge clk) begin
      if (go && !done) begin
        bit exp_rdy, exp_vld, offer, wrapcase;
        exp_rdy = (t - last_acc) >= GAP;
        exp_vld = (q_cyc.size() > 0) && (q_cyc[0] + 4 == t);

        if (t == 0) begin
          chk++;
          if (z_valid !== 1'b0 || in_ready !== 1'b1) begin
            bad++;
            $display("FAIL R1 mode %0d: z_valid=%b in_ready=%b expected 0 1", m, z_valid, in_ready);
          end
        end

        chk++;  // R2 / R5 / R6 readiness cadence
        if (in_ready !== exp_rdy) begin
          bad++;
          $display("FAIL %s mode %0d cycle %0d: in_ready=%b expected %b",
                   OV ? "R6" : "R5", m, t, in_ready, exp_rdy);
        end

        chk++;  // R4 / R8 result timing
        if (z_valid !== exp_vld) begin
          bad++;
          $display("FAIL R4 mode %0d cycle %0d: z_valid=%b expected %b", m, t, z_valid, exp_vld);
        end

        if (exp_vld) begin
          chk++;  // R3 / R7 / R10 value; R9 for wrap operands
          if (z_out !== q_val[0]) begin
            bad++;
            $display("FAIL %s mode %0d cycle %0d: z_out=%h expected %h",
                     q_wrap[0] ? "R9" : "R3", m, t, z_out, q_val[0]);
          end
          n_out++;
          if (n_out == 4) begin
            chk++;  // R5 / R6 throughput over four back-to-back sets
            if ((t - first_acc - 1) != (OV ? 9 : 12)) begin
              bad++;
              $display("FAIL %s mode %0d: four results took %0d cycles expected %0d",
                       OV ? "R6" : "R5", m, t - first_acc - 1, OV ? 9 : 12);
            end
          end
          void'(q_cyc.pop_front());
          void'(q_val.pop_front());
          void'(q_wrap.pop_front());
        end

        // drive this cycle's offer
        if (t < 16)       offer = 1'b1;
        else if (t < 400) offer = ($urandom % 10) < 6;
        else              offer = 1'b0;
        wrapcase = 1'b0;
        if (t % 5 == 0) begin
          a = '1; b = '1; c = '1; d = '1; wrapcase = 1'b1;
        end else if (t % 11 == 0) begin
          a = '0; b = '0; c = '0; d = '0; wrapcase = 1'b1;
        end else begin
          a = W'($urandom); b = W'($urandom); c = W'($urandom); d = W'($urandom);
        end
        in_valid = offer;

        // R10: an offer while not ready must leave the queue untouched
        if (offer && exp_rdy) begin
          longint ra, rb, rc, rd;
          ra = longint'(a); rb = longint'(b); rc = longint'(c); rd = longint'(d);
          q_cyc.push_back(t);
          q_val.push_back(W'((ra * rb + rc + rd) & MASK));
          q_wrap.push_back(wrapcase);
          last_acc = t;
          if (first_acc < 0) first_acc = t;
        end

        t++;
        if (t > 420) begin
          in_valid = 1'b0;
          chk++;
          if (q_cyc.size() != 0) begin
            bad++;
            $display("FAIL R3 mode %0d: %0d results missing expected 0", m, q_cyc.size());
          end
          done = 1'b1;
        end
      end
    end
  end

  initial begin
    int fails;
    int total;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 rst = 1'b0;
    go = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      if (g_mode[0].done && g_mode[1].done) break;
      @(posedge clk);
    end
    total = g_mode[0].chk + g_mode[1].chk;
    fails = g_mode[0].bad + g_mode[1].bad;
    if (!(g_mode[0].done && g_mode[1].done)) begin
      total++;
      fails++;
      $display("FAIL watchdog: run incomplete, done=%b%b expected 11", g_mode[1].done, g_mode[0].done);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

endmodule